// File: doc/BRIEF.md
# Supply Warning Monitor with Flash-Write Gate

This block compares a digitized supply voltage, arriving every cycle as an unsigned millivolt code, against a software-selected threshold with hysteresis. When monitoring is switched on and the supply falls through the threshold, it raises a sticky warning flag. The flag can drive an interrupt line, and software clears it with a clear strobe.

The same comparator also guards a non-volatile memory controller. Each write or erase request it presents is answered one cycle later, either with a grant pulse or with a reject pulse. The gate follows the live comparator state, not the warning flag. Clearing the flag therefore never reopens the flash while the supply is still low.

The comparator only re-arms once the supply has climbed above the threshold plus the hysteresis margin. A flag cleared during a long brown-out therefore does not fire again until the supply has truly recovered and dropped once more.

Top module: `pwr_warn_gate`

## Requirements
- R1: The threshold equals 1700 mV plus 100 mV times the 4-bit select value (select 10 gives 2700 mV). A supply code strictly below the threshold counts as below; a code equal to it does not.
- R2: While enabled and in the armed state, a sample below the threshold sets the warning flag and the below status on the next clock edge.
- R3: Enabling the function while the supply is already below the threshold sets the flag on the first enabled edge.
- R4: The warning flag is never cleared by hardware. It stays set until an edge on which the clear strobe is high.
- R5: After a clear while the supply is still low, the flag is not set again. It re-arms only after a sample strictly above threshold plus HYST_MV (50 mV by default), followed by a sample below the threshold.
- R6: When a clear strobe and a new downward crossing fall on the same edge, the flag ends up set.
- R7: While enabled and in the below state (as updated by the same sample), a request is answered on the next cycle by a one-cycle reject pulse and no grant, whatever the flag holds.
- R8: Any other request gets a one-cycle grant pulse on the next cycle. Cycles without a request produce neither pulse. When disabled, every request is granted, the below status reads 0 and no flag is set.
- R9: The interrupt output is high exactly when the flag and the interrupt-enable input are both high.
- R10: The below status output shows the comparator state. It rises on a sample below the threshold and falls only on a sample above threshold plus hysteresis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vdd_mv | input | VW (12) | Supply sample, unsigned millivolts |
| cfg_en | input | 1 | Monitoring enable |
| cfg_thr | input | SW (4) | Threshold select |
| irq_en | input | 1 | Interrupt enable |
| evt_clr | input | 1 | Warning flag clear strobe |
| req_valid | input | 1 | Write/erase request from the memory controller |
| req_grant | output | 1 | One-cycle grant response |
| req_reject | output | 1 | One-cycle reject response |
| evt_flag | output | 1 | Sticky warning flag |
| irq | output | 1 | Interrupt request |
| below | output | 1 | Live below-threshold status |

## Verification
The hardest state to reach is a flag that has been cleared while the supply stays low. In that state the flag reads 0, yet requests must still be rejected, and a flag that set again would reveal missing hysteresis. A directed sequence builds this state and holds the supply low for several cycles. It then steps the supply to exactly threshold plus hysteresis, where no re-arm may occur, then one millivolt higher, and then back down. A random walk of the supply within 100 mV of the threshold, combined with clear strobes, enable toggles and threshold changes, covers the same-edge set-versus-clear case.

// File: rtl/pwr_warn_gate.sv
module pwr_warn_gate #(
  parameter int VW      = 12,
  parameter int SW      = 4,
  parameter int BASE_MV = 1700,
  parameter int STEP_MV = 100,
  parameter int HYST_MV = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vdd_mv,
  input  logic          cfg_en,
  input  logic [SW-1:0] cfg_thr,
  input  logic          irq_en,
  input  logic          evt_clr,
  input  logic          req_valid,
  output logic          req_grant,
  output logic          req_reject,
  output logic          evt_flag,
  output logic          irq,
  output logic          below
);

  localparam int CW = VW + 1;

  logic [CW-1:0] thr, vext;
  logic          drop, rise, low_q, low_d, set_evt;

  assign thr  = CW'(BASE_MV + STEP_MV * int'(cfg_thr));
  assign vext = {1'b0, vdd_mv};
  assign drop = vext < thr;
  assign rise = vext > (thr + CW'(HYST_MV));

  always_comb begin
    low_d = low_q;
    if (!cfg_en)              low_d = 1'b0;
    else if (!low_q && drop)  low_d = 1'b1;
    else if (low_q && rise)   low_d = 1'b0;
  end

  assign set_evt = cfg_en && !low_q && drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q      <= 1'b0;
      evt_flag   <= 1'b0;
      req_grant  <= 1'b0;
      req_reject <= 1'b0;
    end else begin
      low_q      <= low_d;
      if (set_evt)      evt_flag <= 1'b1;
      else if (evt_clr) evt_flag <= 1'b0;
      req_grant  <= req_valid && !(cfg_en && low_d);
      req_reject <= req_valid && cfg_en && low_d;
    end
  end

  assign below = low_q;
  assign irq   = evt_flag && irq_en;

endmodule

// File: rtl/pwr_warn_gate_chk.sv
module pwr_warn_gate_chk #(
  parameter int VW      = 12,
  parameter int SW      = 4,
  parameter int BASE_MV = 1700,
  parameter int STEP_MV = 100,
  parameter int HYST_MV = 50
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] vdd_mv,
  input logic          cfg_en,
  input logic [SW-1:0] cfg_thr,
  input logic          irq_en,
  input logic          evt_clr,
  input logic          req_valid,
  input logic          req_grant,
  input logic          req_reject,
  input logic          evt_flag,
  input logic          irq,
  input logic          below
);
  logic [VW:0] lim;
  logic        under;
  assign lim   = (VW+1)'(BASE_MV + STEP_MV * int'(cfg_thr));
  assign under = {1'b0, vdd_mv} < lim;

  p_set_on_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && !below && under |=> evt_flag && below);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && !evt_clr |=> evt_flag);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && !below && under && evt_clr |=> evt_flag);
  p_reject_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_en && below && under |=> req_reject && !req_grant);
  p_one_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_grant, req_reject}) == (($past(req_valid)) ? 1 : 0));
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !below);
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_flag && irq_en);
  p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && below && under |=> below);
endmodule

bind pwr_warn_gate pwr_warn_gate_chk #(
  .VW(VW), .SW(SW), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV), .HYST_MV(HYST_MV)
) u_chk (.*);

// File: tb/pwr_warn_gate_test.sv
module pwr_warn_gate_test;
  localparam int VW = 12;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [VW-1:0] vdd_mv = 12'd3300;
  logic          cfg_en = 0;
  logic [3:0]    cfg_thr = 4'd10;
  logic          irq_en = 0;
  logic          evt_clr = 0;
  logic          req_valid = 0;
  logic          req_grant, req_reject, evt_flag, irq, below;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic m_low = 0, m_evt = 0, m_g = 0, m_r = 0;

  always #5 clk = ~clk;

  pwr_warn_gate uut (.*);

  function automatic int thr_of(input logic [3:0] s);
    return 1700 + 100 * int'(s);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic [3:0] s, input int v,
                      input logic clr, input logic ie, input logic rq);
    int t;
    logic nl, sev;
    @(negedge clk);
    cfg_en = en; cfg_thr = s; vdd_mv = VW'(v); evt_clr = clr;
    irq_en = ie; req_valid = rq;
    @(posedge clk);
    t = thr_of(s);
    if (!en) nl = 0;
    else if (!m_low && v < t) nl = 1;
    else if (m_low && v > t + 50) nl = 0;
    else nl = m_low;
    sev = en && !m_low && v < t;
    m_evt = sev ? 1'b1 : (clr ? 1'b0 : m_evt);
    m_g = rq && !(en && nl);
    m_r = rq && en && nl;
    m_low = nl;
    #1;
    chk("R4 flag", evt_flag, m_evt);
    chk("R10 below", below, m_low);
    chk("R8 grant", req_grant, m_g);
    chk("R7 reject", req_reject, m_r);
    chk("R9 irq", irq, m_evt & ie);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #12;
    chk("R8 reset grant", req_grant, 0);
    chk("R4 reset flag", evt_flag, 0);
    chk("R10 reset below", below, 0);
    rst_n = 1;

    // R8: disabled, low supply: granted, no flag
    step(0, 10, 2000, 0, 1, 1);
    chk("R8 disabled grant", req_grant, 1);
    chk("R8 disabled no flag", evt_flag, 0);
    // R1: equal to threshold is not below
    step(1, 10, 2800, 0, 1, 0);
    step(1, 10, 2700, 0, 1, 1);
    chk("R1 equal not below", below, 0);
    chk("R1 equal granted", req_grant, 1);
    // R2: crossing
    step(1, 10, 2699, 0, 1, 0);
    chk("R2 flag set", evt_flag, 1);
    chk("R9 irq high", irq, 1);
    step(1, 10, 2600, 0, 0, 0);
    chk("R9 irq masked", irq, 0);
    // R5/R7: clear while low, flag stays 0, requests still rejected
    step(1, 10, 2600, 1, 1, 0);
    chk("R4 cleared", evt_flag, 0);
    for (int i = 0; i < 4; i++) step(1, 10, 2500 + 40 * i, 0, 1, 1);
    chk("R5 no reset", evt_flag, 0);
    chk("R7 reject with flag clear", req_reject, 1);
    step(1, 10, 2750, 0, 1, 1);
    chk("R5 not rearmed at hyst edge", below, 1);
    chk("R7 still rejected", req_reject, 1);
    step(1, 10, 2751, 0, 1, 1);
    chk("R10 rearmed", below, 0);
    chk("R8 granted after rearm", req_grant, 1);
    step(1, 10, 2650, 0, 1, 0);
    chk("R5 sets after rearm", evt_flag, 1);
    // R6: clear with new crossing same edge
    step(1, 10, 2900, 1, 1, 0);
    step(1, 10, 2600, 1, 1, 0);
    chk("R6 set wins", evt_flag, 1);
    // R3: enable while already low
    step(1, 10, 2600, 1, 1, 0);
    step(0, 10, 2600, 0, 1, 0);
    chk("R8 disabled below clear", below, 0);
    step(1, 10, 2600, 0, 1, 0);
    chk("R3 enable while low", evt_flag, 1);
    // R1: other selects
    step(1, 10, 3300, 1, 1, 0);
    step(1, 0, 1699, 0, 1, 0);
    chk("R1 lowest level", below, 1);
    step(1, 15, 3300, 1, 1, 0);
    step(1, 15, 3199, 0, 1, 1);
    chk("R1 top level", below, 1);
    chk("R7 top level reject", req_reject, 1);

    // random walk around the threshold
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] s;
      int v;
      s = (n % 200 < 100) ? 4'd10 : 4'($urandom % 16);
      v = thr_of(s) - 100 + int'($urandom % 201);
      step(($urandom % 20) != 0, s, v, ($urandom % 8) == 0,
           $urandom % 2, $urandom % 2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule